// File: doc/BRIEF.md
# Sign-Magnitude Shift-Add Multiplier

This block multiplies two signed numbers held in sign-magnitude form. Each operand arrives as one sign bit and an unsigned magnitude of `MAG_W` bits. The result is a sign bit and a magnitude of `2*MAG_W` bits. The result sign is the exclusive-or of the two operand signs. The magnitude comes from a sequential loop, one multiplier bit per clock.

The loop keeps four pieces of state:

- the multiplicand;
- the multiplier, which is shifted out one bit at a time;
- an accumulator that gathers the high half of the product;
- a carry bit.

On each step the block checks the low bit of the multiplier. If that bit is one, the multiplicand is added to the accumulator and the carry out is kept. The combined carry, accumulator and multiplier word is then shifted right by one place. When the step counter runs out, the accumulator holds the high half of the magnitude and the multiplier register holds the low half. If either magnitude is zero, the loop is skipped and a positive zero is returned at once.

A client waits for `ready` and then raises `start` for one cycle with the operands valid. It then watches for the one-cycle `done` pulse. The result outputs keep their value until the next operation is accepted.

Top module: `smmul_top`

## Requirements
- R1: For non-zero operands, `prodSign` at `done` equals `aSign` XOR `bSign`, using the values sampled when the operation was accepted.
- R2: At `done`, `prodMag` equals the unsigned product `aMag * bMag`, using the values sampled at acceptance. The low half holds the low product bits, so the full-scale case gives (2^MAG_W-1)^2 without loss.
- R3: When both magnitudes are non-zero, `done` is high in the cycle after the MAG_W-th rising clock edge that follows the accepting edge.
- R4: When either magnitude is zero, `done` is high in the cycle right after the accepting edge, with `prodMag` = 0 and `prodSign` = 0, whatever the signs.
- R5: `done` is high for exactly one cycle. `ready` is low from acceptance until `done` falls, and `ready` is high in the cycle after `done`.
- R6: An operation is accepted only on a clock edge where `ready` and `start` are both high. `start` pulses and operand changes while busy have no effect on the result or on the timing.
- R7: After reset, `ready` = 1, `done` = 0, `prodMag` = 0 and `prodSign` = 0.
- R8: While idle with `start` low, `prodMag` and `prodSign` hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; taken only while `ready` is high |
| aSign | input | 1 | Sign of multiplicand (1 = negative) |
| aMag | input | MAG_W | Magnitude of multiplicand |
| bSign | input | 1 | Sign of multiplier (1 = negative) |
| bMag | input | MAG_W | Magnitude of multiplier |
| ready | output | 1 | Idle, a new operation may start |
| done | output | 1 | One-cycle pulse: result valid |
| prodSign | output | 1 | Sign of product |
| prodMag | output | 2*MAG_W | Magnitude of product |

## Verification
The bound checker samples the operands at acceptance. On every cycle it checks the following:

- the result sign;
- the result magnitude;
- the exact latency, for both the full loop and the zero-operand shortcut;
- the single-cycle width of `done`;
- that the outputs hold steady while idle.

Only the bench scenarios can show two things. The first is that operand changes and `start` pulses made mid-operation are truly ignored. The second is that the reset values and the spread of sign and magnitude patterns, including full-scale and unit operands, reach the ports as required.

// File: rtl/smmul_pkg.sv
package smmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } smmulState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands (or zero result)
    logic step;   // one conditional add plus right shift
  } smmulCtl_t;

endpackage

// File: rtl/smmul_ctrl.sv
module smmul_ctrl
  import smmul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      opZero,
  output smmulCtl_t ctl,
  output logic      ready,
  output logic      done
);

  localparam int CNT_W = $clog2(MAG_W + 1);
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(MAG_W);

  smmulState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD   = stateQ;
    cntD     = cntQ;
    ctl.load = 1'b0;
    ctl.step = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          cntD     = STEPS;
          stateD   = opZero ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.step = 1'b1;
        cntD     = cntQ - 1'b1;
        if (cntQ == CNT_W'(1)) stateD = ST_FIN;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign ready = (stateQ == ST_IDLE);
  assign done  = (stateQ == ST_FIN);

endmodule

// File: rtl/smmul_dpath.sv
module smmul_dpath
  import smmul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  smmulCtl_t          ctl,
  input  logic               aSign,
  input  logic [MAG_W-1:0]   aMag,
  input  logic               bSign,
  input  logic [MAG_W-1:0]   bMag,
  output logic               opZero,
  output logic               prodSign,
  output logic [2*MAG_W-1:0] prodMag
);

  logic [MAG_W-1:0] mcandQ;   // multiplicand
  logic [MAG_W-1:0] mplrQ;    // multiplier, becomes low half
  logic [MAG_W-1:0] accQ;     // accumulator, becomes high half
  logic             signQ;

  logic [MAG_W-1:0] addend;
  logic [MAG_W:0]   sumCarry; // {carry, accumulator} after the add

  assign opZero   = (aMag == '0) || (bMag == '0);
  assign addend   = mplrQ[0] ? mcandQ : '0;
  assign sumCarry = {1'b0, accQ} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ <= '0;
      mplrQ  <= '0;
      accQ   <= '0;
      signQ  <= 1'b0;
    end else if (ctl.load) begin
      accQ   <= '0;
      mcandQ <= aMag;
      mplrQ  <= opZero ? '0 : bMag;
      signQ  <= opZero ? 1'b0 : (aSign ^ bSign);
    end else if (ctl.step) begin
      // right shift of carry:acc:mplr, carry cleared afterwards
      accQ  <= sumCarry[MAG_W:1];
      mplrQ <= {sumCarry[0], mplrQ[MAG_W-1:1]};
    end
  end

  assign prodSign = signQ;
  assign prodMag  = {accQ, mplrQ};

endmodule

// File: rtl/smmul_top.sv
module smmul_top
  import smmul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               aSign,
  input  logic [MAG_W-1:0]   aMag,
  input  logic               bSign,
  input  logic [MAG_W-1:0]   bMag,
  output logic               ready,
  output logic               done,
  output logic               prodSign,
  output logic [2*MAG_W-1:0] prodMag
);

  smmulCtl_t ctl;
  logic      opZero;

  smmul_ctrl #(.MAG_W(MAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opZero(opZero),
    .ctl(ctl), .ready(ready), .done(done)
  );

  smmul_dpath #(.MAG_W(MAG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .aSign(aSign), .aMag(aMag), .bSign(bSign), .bMag(bMag),
    .opZero(opZero), .prodSign(prodSign), .prodMag(prodMag)
  );

endmodule

// File: rtl/smmul_chk.sv
module smmul_chk #(
  parameter int MAG_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               aSign,
  input logic [MAG_W-1:0]   aMag,
  input logic               bSign,
  input logic [MAG_W-1:0]   bMag,
  input logic               ready,
  input logic               done,
  input logic               prodSign,
  input logic [2*MAG_W-1:0] prodMag
);

  logic [MAG_W-1:0] aLat, bLat;
  logic             sgnLat, zeroLat;
  int unsigned      cyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aLat <= '0; bLat <= '0; sgnLat <= 1'b0; zeroLat <= 1'b0; cyc <= 0;
    end else if (ready && start) begin
      aLat    <= aMag;
      bLat    <= bMag;
      sgnLat  <= aSign ^ bSign;
      zeroLat <= (aMag == '0) || (bMag == '0);
      cyc     <= 0;
    end else if (cyc < 1000) begin
      cyc <= cyc + 1;
    end
  end

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> prodSign == (sgnLat && !zeroLat));

  // R2
  product_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> prodMag == ({{MAG_W{1'b0}}, aLat} * {{MAG_W{1'b0}}, bLat}));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !zeroLat) |-> cyc == MAG_W);

  // R4
  zero_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroLat) |-> (cyc == 0 && prodMag == '0));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && ready));

  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ready);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !start) |=> ($stable(prodMag) && $stable(prodSign)));

endmodule

bind smmul_top smmul_chk #(.MAG_W(MAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start),
  .aSign(aSign), .aMag(aMag), .bSign(bSign), .bMag(bMag),
  .ready(ready), .done(done), .prodSign(prodSign), .prodMag(prodMag)
);

// File: tb/smmul_tb.sv
module smmul_top_tb_top;

  localparam int W = 8;
  localparam int NV = 9;
  // {aSign, aMag, bSign, bMag}
  localparam logic [2*W+1:0] VECS [NV] = '{
    {1'b0, 8'd13,  1'b0, 8'd11},
    {1'b1, 8'd27,  1'b0, 8'd7},
    {1'b0, 8'd100, 1'b1, 8'd3},
    {1'b1, 8'd255, 1'b1, 8'd255},
    {1'b0, 8'd1,   1'b0, 8'd1},
    {1'b1, 8'd128, 1'b0, 8'd2},
    {1'b0, 8'd170, 1'b1, 8'd85},
    {1'b1, 8'd0,   1'b0, 8'd77},
    {1'b1, 8'd200, 1'b0, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic aSign = 1'b0, bSign = 1'b0;
  logic [W-1:0] aMag = '0, bMag = '0;
  logic ready, done, prodSign;
  logic [2*W-1:0] prodMag;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  smmul_top #(.MAG_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .aSign(aSign), .aMag(aMag), .bSign(bSign), .bMag(bMag),
    .ready(ready), .done(done), .prodSign(prodSign), .prodMag(prodMag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // run one operation; disturb = scramble inputs and pulse start while busy
  task automatic runOp(input logic as, input logic [W-1:0] am,
                       input logic bs, input logic [W-1:0] bm,
                       input bit disturb);
    int lat;
    bit isZero;
    isZero = (am == 0) || (bm == 0);
    @(negedge clk);
    check("R5 ready before start", ready, 1);
    start = 1'b1; aSign = as; aMag = am; bSign = bs; bMag = bm;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4 * W) begin
      if (disturb) begin
        aMag = ~am; bMag = bm + 8'd3; aSign = ~as; bSign = bs;
        start = (lat % 2 == 0);
      end
      check("R5 ready low while busy", ready, 0);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(isZero ? "R4 latency" : "R3 latency", lat, isZero ? 0 : W);
    check("R2 product magnitude", prodMag, isZero ? 0 : longint'(am) * longint'(bm));
    check(isZero ? "R4 zero sign" : "R1 sign", prodSign, isZero ? 0 : (as ^ bs));
    if (disturb) check("R6 busy inputs ignored", prodMag, longint'(am) * longint'(bm));
    @(negedge clk);
    check("R5 done one cycle", done, 0);
    check("R5 ready after done", ready, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [2*W-1:0] held;
    logic heldSign;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7 reset state
    check("R7 ready", ready, 1);
    check("R7 done", done, 0);
    check("R7 prodMag", prodMag, 0);
    check("R7 prodSign", prodSign, 0);

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i][2*W+1], VECS[i][2*W:W+1], VECS[i][W], VECS[i][W-1:0], 1'b0);
    end

    // R6 disturbance during an operation
    runOp(1'b1, 8'd99, 1'b0, 8'd57, 1'b1);
    // R6 no spurious second operation: start was low after done
    repeat (3) begin
      @(negedge clk);
      check("R6 no extra done", done, 0);
    end

    // R8 result held while idle with inputs moving
    runOp(1'b0, 8'd45, 1'b1, 8'd6, 1'b0);
    held = prodMag; heldSign = prodSign;
    aMag = 8'd3; bMag = 8'd9; aSign = 1'b0; bSign = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 hold magnitude", prodMag, held);
    check("R8 hold sign", prodSign, heldSign);

    // R4 zero with both signs negative gives positive zero
    runOp(1'b1, 8'd0, 1'b1, 8'd0, 1'b0);
    // R2 full scale again after zero case
    runOp(1'b0, 8'd255, 1'b0, 8'd255, 1'b0);

    finishRun();
  end

endmodule